// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a 5x5 key matrix and drives it only when something happens. While idle, every row output is held low and the five active-low column returns are compared against the stored key picture. When the comparison shows that a key was pressed or released, the block starts to scan. It raises one row at a time, from the first row to the last, holds each row for a fixed number of clocks, and on the last clock of each row pulse it copies the inverted columns into that row's part of a 25-bit key image.

The first complete pass over all five rows raises the interrupt. The host then reads the image. It can clear the interrupt with an acknowledge strobe, and it ends scanning with a stop strobe. If a key changed after that first pass was complete, one stop strobe only clears the pending change and scanning goes on. A second stop strobe is then needed, so a key that moved during service is not lost.

Top module: `kscan_top`

## Requirements
- R1: After reset, all row outputs are low, the key image is all zeros and the interrupt is low.
- R2: While not scanning, all row outputs stay low, and the block does not start scanning as long as the pressed-column pattern (the inverted `col_n`) equals the OR of the five image rows.
- R3: While idle, a mismatch between the pressed-column pattern and the OR of the image rows, caused by either a press or a release, starts scanning on the next clock with only the first row (bit 0 of `row_o`) high.
- R4: While scanning, exactly one row output is high. Each row is held for PULSE_CYCLES clocks, and the rows advance in the order bit 0, 1, 2, 3, 4, then wrap back to bit 0.
- R5: On the last clock of row i's pulse, image bits i*COLS+j (j = 0..4) take the value of the inverted `col_n[j]`, so key Sij is bit (i-1)*5+(j-1) and a 1 means the switch is on.
- R6: The interrupt rises on the clock edge that ends the first complete pass after scanning starts, which is 5*PULSE_CYCLES clocks after the start edge, and not earlier.
- R7: Once high, the interrupt stays high until a stop strobe halts scanning or an acknowledge strobe clears it. An acknowledge strobe drives it low on the next clock.
- R8: A stop strobe while scanning with no pending change halts scanning: on the next clock all rows are low and the interrupt is low.
- R9: A row sample that differs from the stored image after the first pass is complete marks a pending change. A stop strobe seen while the change is pending only clears it, so scanning and the interrupt continue, and a later stop strobe halts scanning.
- R10: A stop strobe while idle has no effect: the rows stay low and no scan starts.
- R11: The interrupt is raised only at the end of the first pass. After an acknowledge, later passes in the same scan session do not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_n | input | COLS | Column returns, active low (0 = key closed on the driven row) |
| stop_cmd | input | 1 | One-clock stop command strobe from the host interface |
| read_ack | input | 1 | One-clock read/acknowledge strobe, clears the interrupt |
| row_o | output | ROWS | Row drive lines, one high at a time while scanning |
| key_image | output | ROWS*COLS | Stored key states, bit i*COLS+j is row i, column j |
| irq | output | 1 | Interrupt, high after the first complete scan pass |

## Verification
On every clock, the assertions check that the rows form a one-hot pulse that only ever steps to the next row. They also check that an effective stop empties the rows and drops the interrupt, that a stop seen while a change is pending leaves scanning running, that the interrupt holds without a clearing strobe, and that it rises only right after the last row's pulse. Other behaviour depends on how the key matrix answers the row drive, and only the bench scenarios can show it. This covers starting on a press and on a release, the image bit positions, a key that moves after the first pass and so forces two stops, and the absence of a second interrupt after an acknowledge.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/kscan_timer.sv
// Row pulse sequencer: one-hot row register plus per-pulse tick counter.
module kscan_timer #(
  parameter int ROWS         = 5,
  parameter int PULSE_CYCLES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            halt,
  output logic [ROWS-1:0] row_oh,
  output logic            sample,
  output logic            cycle_end
);
  localparam int TW = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(PULSE_CYCLES - 1);

  logic [TW-1:0] tick_q;
  logic          active;

  assign active    = |row_oh;
  assign sample    = active && (tick_q == TICK_LAST);
  assign cycle_end = sample && row_oh[ROWS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      row_oh <= '0;
      tick_q <= '0;
    end else if (halt) begin
      row_oh <= '0;
      tick_q <= '0;
    end else if (start) begin
      row_oh <= ROWS'(1);
      tick_q <= '0;
    end else if (active) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        row_oh <= {row_oh[ROWS-2:0], row_oh[ROWS-1]};
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kscan_image.sv
// Key image storage and change detection against the column returns.
module kscan_image #(
  parameter int ROWS = 5,
  parameter int COLS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [COLS-1:0]      col_n,
  input  logic [ROWS-1:0]      row_oh,
  input  logic                 wr,
  output logic [ROWS*COLS-1:0] image,
  output logic                 idle_change,
  output logic                 row_diff
);
  logic [COLS-1:0] pressed;
  logic [COLS-1:0] row_q [ROWS];
  logic [COLS-1:0] col_any;
  logic [COLS-1:0] sel_row;

  assign pressed = ~col_n;

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (rst) begin
        row_q[r] <= '0;
      end else if (wr && row_oh[r]) begin
        row_q[r] <= pressed;
      end
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_pack
    assign image[g*COLS +: COLS] = row_q[g];
  end

  always_comb begin
    col_any = '0;
    sel_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      col_any = col_any | row_q[r];
      if (row_oh[r]) sel_row = sel_row | row_q[r];
    end
  end

  assign idle_change = (pressed != col_any);
  assign row_diff    = (pressed != sel_row);
endmodule

// File: rtl/kscan_ctrl.sv
// Scan session control: start/halt decisions, first-pass tracking,
// pending-change flag and interrupt.
module kscan_ctrl
  import kscan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic idle_change,
  input  logic sample,
  input  logic cycle_end,
  input  logic row_diff,
  input  logic stop_cmd,
  input  logic read_ack,
  output logic start,
  output logic halt,
  output logic pend,
  output logic irq
);
  scan_state_e state_q;
  logic        first_q;

  assign start = (state_q == ST_IDLE) && idle_change;
  assign halt  = (state_q == ST_SCAN) && stop_cmd && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      pend    <= 1'b0;
      irq     <= 1'b0;
    end else if (halt) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      pend    <= 1'b0;
      irq     <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (read_ack) irq <= 1'b0;
      if (start) begin
        state_q <= ST_SCAN;
        first_q <= 1'b1;
      end
    end else begin
      if (cycle_end && first_q) first_q <= 1'b0;
      if (sample && row_diff && !first_q) pend <= 1'b1;
      else if (stop_cmd)                  pend <= 1'b0;
      if (cycle_end && first_q) irq <= 1'b1;
      else if (read_ack)        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/kscan_top.sv
module kscan_top #(
  parameter int ROWS         = 5,
  parameter int COLS         = 5,
  parameter int PULSE_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [COLS-1:0]      col_n,
  input  logic                 stop_cmd,
  input  logic                 read_ack,
  output logic [ROWS-1:0]      row_o,
  output logic [ROWS*COLS-1:0] key_image,
  output logic                 irq
);
  logic start_w, halt_w, pend_w;
  logic sample_w, cycle_end_w;
  logic idle_change_w, row_diff_w;

  kscan_timer #(.ROWS(ROWS), .PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start_w), .halt(halt_w),
    .row_oh(row_o), .sample(sample_w), .cycle_end(cycle_end_w)
  );

  kscan_image #(.ROWS(ROWS), .COLS(COLS)) u_image (
    .clk(clk), .rst(rst), .col_n(col_n), .row_oh(row_o),
    .wr(sample_w && !halt_w), .image(key_image),
    .idle_change(idle_change_w), .row_diff(row_diff_w)
  );

  kscan_ctrl u_ctrl (
    .clk(clk), .rst(rst), .idle_change(idle_change_w),
    .sample(sample_w), .cycle_end(cycle_end_w), .row_diff(row_diff_w),
    .stop_cmd(stop_cmd), .read_ack(read_ack),
    .start(start_w), .halt(halt_w), .pend(pend_w), .irq(irq)
  );
endmodule

// File: rtl/kscan_checker.sv
module kscan_checker #(
  parameter int ROWS = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] row_o,
  input logic            irq,
  input logic            stop_cmd,
  input logic            read_ack,
  input logic            pend
);
  logic [ROWS-1:0] prev_q;
  always_ff @(posedge clk) prev_q <= row_o;

  assert_row_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_o));

  assert_row_order_R4: assert property (@(posedge clk) disable iff (rst)
    (prev_q != '0 && row_o != '0 && row_o != prev_q)
      |-> row_o == {prev_q[ROWS-2:0], prev_q[ROWS-1]});

  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (rst)
    (row_o != '0 && stop_cmd && !pend) |=> (row_o == '0 && !irq));

  assert_pending_keeps_scan_R9: assert property (@(posedge clk) disable iff (rst)
    (row_o != '0 && stop_cmd && pend) |=> (row_o != '0));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !read_ack && !stop_cmd) |=> irq);

  assert_irq_after_last_row_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> prev_q[ROWS-1]);
endmodule

bind kscan_top kscan_checker #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .row_o(row_o), .irq(irq),
  .stop_cmd(stop_cmd), .read_ack(read_ack), .pend(pend_w)
);

// File: tb/test_kscan_top.sv
module test_kscan_top;
  localparam int ROWS = 5;
  localparam int COLS = 5;
  localparam int P    = 4;
  localparam int NB   = ROWS * COLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_cmd = 1'b0;
  logic read_ack = 1'b0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_o;
  logic [NB-1:0]   key_image;
  logic            irq;
  logic [NB-1:0]   keys = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  kscan_top #(.ROWS(ROWS), .COLS(COLS), .PULSE_CYCLES(P)) i_kscan_top (
    .clk(clk), .rst(rst), .col_n(col_n), .stop_cmd(stop_cmd),
    .read_ack(read_ack), .row_o(row_o), .key_image(key_image), .irq(irq)
  );

  // Key matrix: idle rows all low connect every row; a driven row alone otherwise.
  always_comb begin
    logic [COLS-1:0] c;
    c = '0;
    for (int i = 0; i < ROWS; i++)
      if (row_o == '0 || row_o[i]) c = c | keys[i*COLS +: COLS];
    col_n = ~c;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit          m_scan, m_first, m_pend, m_irq;
  int          m_row, m_tick;
  logic [NB-1:0] m_img;

  function automatic logic [COLS-1:0] model_cols();
    logic [COLS-1:0] c = '0;
    for (int i = 0; i < ROWS; i++)
      if (!m_scan || m_row == i) c = c | keys[i*COLS +: COLS];
    return c;
  endfunction

  function automatic logic [COLS-1:0] img_or();
    logic [COLS-1:0] c = '0;
    for (int i = 0; i < ROWS; i++) c = c | m_img[i*COLS +: COLS];
    return c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_scan = 0; m_first = 0; m_pend = 0; m_irq = 0;
      m_row = 0; m_tick = 0; m_img = '0;
    end else begin
      logic [COLS-1:0] cols;
      bit n_pend, n_irq;
      cols = model_cols();
      if (!m_scan) begin
        if (read_ack) m_irq = 0;
        if (cols != img_or()) begin
          m_scan = 1; m_row = 0; m_tick = 0; m_first = 1;
        end
      end else if (stop_cmd && !m_pend) begin
        m_scan = 0; m_first = 0; m_pend = 0; m_irq = 0; m_row = 0; m_tick = 0;
      end else begin
        n_pend = m_pend; n_irq = m_irq;
        if (stop_cmd) n_pend = 0;
        if (read_ack) n_irq = 0;
        if (m_tick == P - 1) begin
          if (m_img[m_row*COLS +: COLS] != cols && !m_first) n_pend = 1;
          m_img[m_row*COLS +: COLS] = cols;
          m_tick = 0;
          if (m_row == ROWS - 1) begin
            m_row = 0;
            if (m_first) begin n_irq = 1; m_first = 0; end
          end else m_row++;
        end else m_tick++;
        m_pend = n_pend; m_irq = n_irq;
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 rows vs model", 32'(row_o), m_scan ? 32'(1 << m_row) : 32'd0);
      check("R5 image vs model", 32'(key_image), 32'(m_img));
      check("R7 irq vs model", 32'(irq), 32'(m_irq));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
  endtask

  initial begin
    step(3);
    check("R1 rows after reset", 32'(row_o), 0);
    check("R1 image after reset", 32'(key_image), 0);
    check("R1 irq after reset", 32'(irq), 0);
    rst = 1'b0;

    step(5);
    check("R2 idle rows low", 32'(row_o), 0);
    pulse_stop();
    step(2);
    check("R10 stop while idle rows", 32'(row_o), 0);
    check("R10 stop while idle irq", 32'(irq), 0);

    // Press S23 -> bit 7
    keys[7] = 1'b1;
    step(1);
    check("R3 press starts with first row", 32'(row_o), 32'h1);
    step(P);
    check("R4 second row after one pulse", 32'(row_o), 32'h2);
    step(4*P - 1);
    check("R6 irq low before pass ends", 32'(irq), 0);
    step(1);
    check("R6 irq high after first pass", 32'(irq), 1);
    check("R5 S23 stored at bit 7", 32'(key_image), 32'h80);

    read_ack = 1'b1;
    step(1);
    read_ack = 1'b0;
    check("R7 ack clears irq", 32'(irq), 0);
    step(5*P + 2);
    check("R11 no second irq in session", 32'(irq), 0);
    check("R9 still scanning", 32'(row_o != 0), 1);

    pulse_stop();
    check("R8 stop empties rows", 32'(row_o), 0);
    check("R8 stop drops irq", 32'(irq), 0);
    step(3);
    check("R2 no restart when unchanged", 32'(row_o), 0);
    check("R2 image kept while idle", 32'(key_image), 32'h80);

    // Release S23
    keys[7] = 1'b0;
    step(1);
    check("R3 release starts scan", 32'(row_o), 32'h1);
    step(5*P);
    check("R6 irq after release pass", 32'(irq), 1);
    check("R5 release cleared image", 32'(key_image), 0);

    // Press S45 -> bit 19, after the first pass is done
    keys[19] = 1'b1;
    step(6*P);
    check("R5 S45 stored at bit 19", 32'(key_image), 32'h80000);
    pulse_stop();
    check("R9 first stop ignored rows", 32'(row_o != 0), 1);
    check("R9 first stop keeps irq", 32'(irq), 1);
    step(2);
    pulse_stop();
    check("R9 second stop halts rows", 32'(row_o), 0);
    check("R9 second stop drops irq", 32'(irq), 0);
    step(4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule